// File: doc/BRIEF.md
# Reference-Clock Frequency Meter

This block measures a slow clock against a fast reference clock. It counts how many reference cycles pass during a window. The window is a whole number of slow-clock periods, and software sets that number through a control field. The slow clock is not used as a clock inside the block. It is sampled as data in the reference domain, passed through a two-flop synchronizer, and watched for rising edges. Because the window both opens and closes on a synchronized edge, the synchronizer delay appears at both ends and does not change the count.

Software uses the block in this order. It pulses the soft reset to clear the previous result. It sets the reference-enable bit, then sets the meter-enable bit to start a measurement. It polls the busy flag until it drops, then reads the count. When the count is final, clearing meter-enable returns the meter to idle. Clearing meter-enable at any earlier point abandons the measurement. A window setting of N covers N+1 slow periods. A setting of zero therefore measures a single period. For example, a 26 MHz reference against a nominal 32 kHz slow clock gives a single-period count of about 794.

Top module: `refclk_freq_meter`

## Requirements
- R1: When the slow clock has a steady period of P reference cycles, a completed measurement with window setting W reports count = P*(W+1). The high and low phases may have any lengths. The count is the number of reference cycles from the first synchronized slow rising edge after start to the (W+1)-th rising edge after that one.
- R2: A window setting of 0 measures exactly one slow period, so the count equals P.
- R3: Busy goes high on the first reference edge after a start. It falls on the same reference edge at which the final count appears on the count output.
- R4: If meter-enable goes low while busy is high, busy is low after the next reference edge and the meter is idle.
- R5: While soft reset is high, count is 0 and busy is 0 after each reference edge. After soft reset is released, the meter is idle. A meter-enable bit that was already high through the soft reset does not start a measurement.
- R6: A measurement starts only on a 0-to-1 change of meter-enable, and only while reference-enable is already 1. Setting reference-enable while meter-enable is already high starts nothing. Count and busy stay unchanged.
- R7: The 16-bit count saturates at 65535 instead of wrapping.
- R8: After busy falls, count holds its value until a soft reset or the next start. Leaving meter-enable high after completion does not restart the meter.
- R9: While rst_n is low, count is 0 and busy is 0 after each reference edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Fast reference clock; all state is clocked on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_slow | input | 1 | Slow clock to be measured, sampled asynchronously |
| soft_rst | input | 1 | Control bit: clears result and busy, forces idle |
| ref_en | input | 1 | Control bit: reference enabled, must be set before starting |
| meas_en | input | 1 | Control bit: a 0-to-1 change starts a measurement, 0 abandons or ends it |
| win_size | input | WIN_W (8) | Window length in slow periods minus one |
| busy | output | 1 | High while a measurement is in progress |
| count | output | CNT_W (16) | Reference cycles counted in the window, saturating |

## Verification
The assertions check the following rules on every cycle:
- Abandoning a measurement drops busy one cycle later.
- Soft reset clears the count and busy.
- No start happens while reference-enable is low.
- The count never decreases during a measurement.
- A saturated count stays at 65535.
- The count holds while the meter is idle with meter-enable low.

Only the bench scenarios show the remaining behaviour. These are the exact relation count = P*(W+1) over a range of slow periods, duty cycles and window settings, and the single-period case. They also cover the start rule that depends on ordering (reference-enable set late) and the no-restart-after-done case. Finally, they show saturation in a window longer than 65535 reference cycles.

// File: rtl/fm_pkg.sv
// Package: shared types of the reference-clock frequency meter.
// Assumes: nothing beyond a common reference clock domain.
package fm_pkg;

    // Sequencer states: idle, waiting for the opening edge, counting, result held.
    typedef enum logic [1:0] {
        FM_IDLE = 2'd0,
        FM_ARM  = 2'd1,
        FM_RUN  = 2'd2,
        FM_DONE = 2'd3
    } fm_state_t;

endpackage

// File: rtl/fm_edge_sync.sv
// Module: fm_edge_sync
// Brings an asynchronous slow clock into the reference domain through a
// chain of STAGES flops. It then flags each rising edge of the synchronized
// signal as a one-cycle pulse.
// Assumes: the slow clock stays high and low for at least two reference
// cycles each, so that no edge is lost in the chain. STAGES >= 2.
module fm_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);

    logic [STAGES-1:0] chain;
    logic              last_q;

    // Synchronizer chain: the asynchronous input enters bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], din};
        end
    end

    // Delayed copy of the synchronized level, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= 1'b0;
        end else begin
            last_q <= chain[STAGES-1];
        end
    end

    // Rising edge is a pulse of one reference cycle.
    always_comb begin
        rise = chain[STAGES-1] & ~last_q;
    end

endmodule

// File: rtl/fm_ctrl.sv
// Module: fm_ctrl
// Measurement sequencer. A start is a rising meter-enable while the
// reference enable is already set. The sequencer then waits for the first
// synchronized slow edge and counts slow edges until the window closes.
// It commands the result counter to clear and to increment.
// Assumes: slow_rise is a one-cycle pulse in this clock domain.
module fm_ctrl
    import fm_pkg::*;
#(
    parameter int WIN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             ref_en,
    input  logic             meas_en,
    input  logic [WIN_W-1:0] win_size,
    input  logic             slow_rise,
    output logic             busy,
    output logic             cnt_clr,
    output logic             cnt_inc
);

    fm_state_t        state_q;
    fm_state_t        state_d;
    logic             meas_en_q;
    logic             start;
    logic [WIN_W-1:0] win_q;
    logic [WIN_W-1:0] edge_q;
    logic             window_end;

    // Previous meter-enable level, for detecting the start edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meas_en_q <= 1'b0;
        end else begin
            meas_en_q <= meas_en;
        end
    end

    // Start request: a new meter-enable edge, reference already on, not in reset.
    always_comb begin
        start = meas_en & ~meas_en_q & ref_en & ~soft_rst;
    end

    // Closing edge: the (win+1)-th rising edge after the opening one.
    always_comb begin
        window_end = (state_q == FM_RUN) && slow_rise && (edge_q == win_q);
    end

    // Next-state logic of the sequencer.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FM_IDLE: if (start) state_d = FM_ARM;
            FM_ARM:  if (!meas_en) state_d = FM_IDLE;
                     else if (slow_rise) state_d = FM_RUN;
            FM_RUN:  if (!meas_en) state_d = FM_IDLE;
                     else if (window_end) state_d = FM_DONE;
            FM_DONE: if (!meas_en) state_d = FM_IDLE;
            default: state_d = FM_IDLE;
        endcase
        if (soft_rst) begin
            state_d = FM_IDLE;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FM_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Window length captured at start so a later field change cannot disturb it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= '0;
        end else if (start && state_q == FM_IDLE) begin
            win_q <= win_size;
        end
    end

    // Slow edges seen since the window opened.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_q <= '0;
        end else if (state_q == FM_ARM) begin
            edge_q <= '0;
        end else if (state_q == FM_RUN && slow_rise && !window_end) begin
            edge_q <= edge_q + 1'b1;
        end
    end

    // Outputs decoded from the registered state.
    always_comb begin
        busy    = (state_q == FM_ARM) || (state_q == FM_RUN);
        cnt_inc = (state_q == FM_RUN) && meas_en && !soft_rst;
        cnt_clr = soft_rst || (start && state_q == FM_IDLE);
    end

endmodule

// File: rtl/fm_sat_counter.sv
// Module: fm_sat_counter
// Result counter. It clears on request and increments by one per enabled
// cycle. At its maximum value it stops instead of wrapping.
// Assumes: clear has priority over increment.
module fm_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);

    localparam logic [W-1:0] MAX_VAL = {W{1'b1}};

    // Counter register with clear, saturating increment and hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (clr) begin
            q <= '0;
        end else if (inc && q != MAX_VAL) begin
            q <= q + 1'b1;
        end
    end

endmodule

// File: rtl/refclk_freq_meter.sv
// Module: refclk_freq_meter (top)
// Counts reference-clock cycles over a window of (win_size+1) periods of a
// slow clock. The slow clock is sampled as data in the reference domain.
// Assumes: a single reference clock, a synchronous active-low reset, and
// control bits driven in the reference domain.
module refclk_freq_meter #(
    parameter int WIN_W       = 8,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_ref,
    input  logic             rst_n,
    input  logic             clk_slow,
    input  logic             soft_rst,
    input  logic             ref_en,
    input  logic             meas_en,
    input  logic [WIN_W-1:0] win_size,
    output logic             busy,
    output logic [CNT_W-1:0] count
);

    logic slow_rise;
    logic cnt_clr;
    logic cnt_inc;

    fm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk_ref),
        .rst_n (rst_n),
        .din   (clk_slow),
        .rise  (slow_rise)
    );

    fm_ctrl #(.WIN_W(WIN_W)) u_ctrl (
        .clk       (clk_ref),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .ref_en    (ref_en),
        .meas_en   (meas_en),
        .win_size  (win_size),
        .slow_rise (slow_rise),
        .busy      (busy),
        .cnt_clr   (cnt_clr),
        .cnt_inc   (cnt_inc)
    );

    fm_sat_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk_ref),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .q     (count)
    );

endmodule

// File: rtl/fm_checker.sv
// Module: fm_checker
// Property checks on the frequency meter ports, attached by bind.
// Assumes: the same clock and reset as the top module.
module fm_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk_ref,
    input logic             rst_n,
    input logic             soft_rst,
    input logic             ref_en,
    input logic             meas_en,
    input logic             busy,
    input logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // R4: abandoning a measurement ends busy on the next edge.
    a_r4_abort_idles: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (busy && !meas_en) |=> !busy);

    // R5: soft reset clears the result and busy.
    a_r5_soft_reset_clears: assert property (@(posedge clk_ref) disable iff (!rst_n)
        soft_rst |=> (count == '0 && !busy));

    // R6: no start while reference enable is low.
    a_r6_no_start_without_ref: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (!busy && !ref_en) |=> !busy);

    // R1: the count never decreases while a measurement runs.
    a_r1_count_monotonic: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (busy && !soft_rst) |=> (count >= $past(count)));

    // R7: a saturated count stays at its maximum.
    a_r7_no_overflow: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (busy && !soft_rst && count == CNT_MAX) |=> (count == CNT_MAX));

    // R8: the result holds while idle with meter-enable low.
    a_r8_result_holds: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (!busy && !soft_rst && !meas_en) |=> $stable(count));

endmodule

bind refclk_freq_meter fm_checker #(.CNT_W(CNT_W)) u_fm_checker (
    .clk_ref  (clk_ref),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .ref_en   (ref_en),
    .meas_en  (meas_en),
    .busy     (busy),
    .count    (count)
);

// File: tb/sim_refclk_freq_meter.sv
// Bench for refclk_freq_meter. The slow clock is generated from the
// reference so that expected counts are exact.
module sim_refclk_freq_meter;

    localparam int WIN_W = 8;
    localparam int CNT_W = 16;

    logic             clk_ref = 1'b0;
    logic             rst_n = 1'b0;
    logic             clk_slow = 1'b0;
    logic             soft_rst = 1'b0;
    logic             ref_en = 1'b0;
    logic             meas_en = 1'b0;
    logic [WIN_W-1:0] win_size = '0;
    logic             busy;
    logic [CNT_W-1:0] count;

    int n_checks = 0;
    int n_fails  = 0;
    int hi_len   = 12;
    int lo_len   = 12;
    int phase    = 0;
    bit finished = 1'b0;

    refclk_freq_meter #(.WIN_W(WIN_W), .CNT_W(CNT_W)) u0 (
        .clk_ref  (clk_ref),
        .rst_n    (rst_n),
        .clk_slow (clk_slow),
        .soft_rst (soft_rst),
        .ref_en   (ref_en),
        .meas_en  (meas_en),
        .win_size (win_size),
        .busy     (busy),
        .count    (count)
    );

    // 250 MHz reference clock.
    always #2 clk_ref = ~clk_ref;

    // Slow clock derived from the reference: hi_len cycles high, lo_len low.
    always @(negedge clk_ref) begin
        phase = phase + 1;
        if (clk_slow && phase >= hi_len) begin
            clk_slow = 1'b0;
            phase = 0;
        end else if (!clk_slow && phase >= lo_len) begin
            clk_slow = 1'b1;
            phase = 0;
        end
    end

    function automatic int exp_count(int period, int win);
        int raw;
        raw = period * (win + 1);
        return (raw > 65535) ? 65535 : raw;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycles(int n);
        for (int i = 0; i < n; i++) @(negedge clk_ref);
    endtask

    task automatic set_slow(int hi, int lo);
        hi_len = hi;
        lo_len = lo;
        cycles(3 * (hi + lo) + 4);
    endtask

    // Start a measurement and check busy rises on the next edge (R3).
    task automatic start_meas(int win);
        @(negedge clk_ref);
        meas_en  = 1'b0;
        ref_en   = 1'b1;
        win_size = WIN_W'(win);
        @(negedge clk_ref);
        meas_en = 1'b1;
        @(negedge clk_ref);
        chk("R3 busy after start", int'(busy), 1);
    endtask

    // Wait for busy to fall; returns the count seen at that moment.
    task automatic wait_done(int limit, output int result);
        int n;
        n = 0;
        while (busy && n < limit) begin
            @(negedge clk_ref);
            n++;
        end
        chk("R3 busy falls", int'(busy), 0);
        result = int'(count);
    endtask

    task automatic measure(int hi, int lo, int win, string req);
        int res;
        set_slow(hi, lo);
        start_meas(win);
        wait_done((hi + lo) * (win + 4) + 50, res);
        chk(req, res, exp_count(hi + lo, win));
        @(negedge clk_ref);
        meas_en = 1'b0;
    endtask

    initial begin
        int held;
        int res;
        void'($urandom(32'd20240611));

        // R9: synchronous reset state.
        cycles(4);
        chk("R9 busy in reset", int'(busy), 0);
        chk("R9 count in reset", int'(count), 0);
        rst_n = 1'b1;
        cycles(2);

        // R2: one-period window.
        measure(12, 12, 0, "R2 single period");

        // R8: meter-enable left high after completion.
        start_meas(2);
        wait_done(200, held);
        chk("R1 three periods", held, 72);
        cycles(100);
        chk("R8 no restart busy", int'(busy), 0);
        chk("R8 count holds high", int'(count), held);
        meas_en = 1'b0;
        cycles(30);
        chk("R8 count holds low", int'(count), held);

        // R1: asymmetric duty cycle.
        measure(3, 7, 5, "R1 asymmetric");

        // R1: random periods and windows.
        for (int k = 0; k < 14; k++) begin
            int hi;
            int lo;
            int w;
            hi = 2 + int'($urandom_range(18));
            lo = 2 + int'($urandom_range(18));
            w  = int'($urandom_range(7));
            measure(hi, lo, w, "R1 random");
        end
        held = int'(count);

        // R6: reference enable set after meter enable.
        @(negedge clk_ref);
        ref_en  = 1'b0;
        @(negedge clk_ref);
        meas_en = 1'b1;
        cycles(60);
        chk("R6 no start ref low", int'(busy), 0);
        ref_en = 1'b1;
        cycles(60);
        chk("R6 no start ref late", int'(busy), 0);
        chk("R6 count untouched", int'(count), held);
        meas_en = 1'b0;
        cycles(2);

        // R4: abandon mid-measurement.
        set_slow(20, 20);
        start_meas(7);
        cycles(100);
        chk("R4 busy mid run", int'(busy), 1);
        meas_en = 1'b0;
        @(negedge clk_ref);
        chk("R4 abort idles", int'(busy), 0);
        cycles(5);

        // R5: soft reset during a measurement, meter-enable kept high.
        start_meas(7);
        cycles(100);
        soft_rst = 1'b1;
        @(negedge clk_ref);
        chk("R5 busy cleared", int'(busy), 0);
        chk("R5 count cleared", int'(count), 0);
        soft_rst = 1'b0;
        cycles(100);
        chk("R5 idle after release", int'(busy), 0);
        meas_en = 1'b0;
        measure(20, 20, 1, "R5 measure after soft reset");
        soft_rst = 1'b1;
        @(negedge clk_ref);
        soft_rst = 1'b0;
        chk("R5 clears held result", int'(count), 0);

        // R7: window longer than the counter range.
        set_slow(150, 150);
        start_meas(220);
        wait_done(300 * 224, res);
        chk("R7 saturates", res, 65535);
        meas_en = 1'b0;

        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 4);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule